// File: doc/BRIEF.md
# Raster Display Timing Generator with Frame-Synchronous Register Update

This block drives the timing side of a raster display. From a programmed set of horizontal and vertical segment lengths (sync pulse, back porch, active region, front porch) it produces horizontal sync, vertical sync, a data-enable strobe and the zero-based column and row of the pixel being shown. A pixel data path elsewhere in the chip uses data-enable and the coordinates to place its pixels. One clock cycle is one pixel.

Software programs the block through a small write port and reads it back through a registered read port. Each timing write lands in a shadow copy. The shadow copy moves into the working copy that the counters use only at a frame boundary, so a mode change never tears a frame. The block flags each frame end in a sticky status bit. An enable bit masks that bit onto an interrupt line, and writing a one to the clear register clears it. Control bits turn the generator on, gate data-enable, and make each sync active-low.

Register map, 3-bit word address: 0 control, 1 horizontal porches, 2 horizontal sync width, 3 vertical porches, 4 vertical sync width, 5 active size, 6 interrupt enable, 7 interrupt clear on write and masked status on read.

Top module: `disp_tgen`

## Requirements
- R1: A line is made of hsync, then back porch, then active, then front porch, in that order. It lasts hsync+back porch+active+front porch cycles. A frame is made of lines in the same order on the vertical axis, so frame length = line length x line count.
- R2: The sync widths and the active size are programmed as value minus one: address 2 bits [11:0] hold hsync width-1, and address 5 holds height-1 in [27:16] and width-1 in [11:0]. Porches are programmed as plain values: addresses 1 and 3 hold back porch in [27:16] and front porch in [11:0].
- R3: Address 4 bits [3:0] hold vsync width-1. The vsync pulse lasts at most 15 lines, so a field value of 15 gives 15 lines. Read-back returns the field as written.
- R4: de_o is high only where both the horizontal and the vertical active regions hold. px_x and px_y count from 0 at the first active pixel and line, and read 0 outside the active area.
- R5: Writes to addresses 1 through 5 are returned by a read at once. They take effect only at the next frame end, so the frame in progress keeps its length. A read returns its value on rd_data one cycle after rd_addr is presented.
- R6: frame_end_o is a single-cycle pulse. It comes in the cycle right after the cycle in which de_o shows the last active pixel of the last active line.
- R7: Each frame end sets a sticky status bit. Address 6 bit 0 enables it. irq_o and a read of address 7 bit 0 show status AND enable, and irq_o rises in the frame_end_o cycle.
- R8: Writing 1 to address 7 bit 0 clears the status bit. If a clear write and a frame end fall on the same clock edge, the status bit stays set.
- R9: Control bit 2 makes hsync_o active-low, and control bit 3 makes vsync_o active-low.
- R10: Control bit 0 enables the generator. When it is clear, de_o is low, frame_end_o stays low, and both syncs sit at their inactive levels. Control bit 1 gates data-enable: when it is clear, de_o stays low while timing and frame_end_o continue.
- R11: After reset the generator is disabled, the syncs, de_o, frame_end_o and irq_o are low, and the working set is the default mode of 2+3+8+2 cycles by 1+2+4+1 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| px_x | output | CW | Active column |
| px_y | output | CW | Active row |
| frame_end_o | output | 1 | Frame-end pulse |
| irq_o | output | 1 | Masked frame-end interrupt |

## Verification
The clear write and the frame-end event that sets the status bit can land on the same clock edge. The same edge is also where the shadow copy moves into the working set. The bench counts forward from one frame-end pulse to the cycle just before the next one and presents the clear write there. It then expects frame_end_o and irq_o high together, and irq_o still high some cycles later, because the set must win. A separate case writes the active size just after a frame end and expects that frame to keep the old length, with the new geometry showing only one frame later.

// File: rtl/disp_tgen_pkg.sv
package disp_tgen_pkg;
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_HPOR  = 3'd1,
    RA_HSW   = 3'd2,
    RA_VPOR  = 3'd3,
    RA_VSW   = 3'd4,
    RA_SIZE  = 3'd5,
    RA_IEN   = 3'd6,
    RA_ICLR  = 3'd7
  } reg_addr_e;

  localparam int CB_GEN   = 0;
  localparam int CB_DGATE = 1;
  localparam int CB_HNEG  = 2;
  localparam int CB_VNEG  = 3;
  localparam int HI_LSB   = 16;
  localparam int VSW_BITS = 4;
  localparam int VSW_CAP  = 15;
endpackage

// File: rtl/tgen_axis.sv
module tgen_axis #(
  parameter int TW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic [TW-1:0] sync_len,
  input  logic [TW-1:0] bp_len,
  input  logic [TW-1:0] act_len,
  input  logic [TW-1:0] fp_len,
  output logic          in_sync,
  output logic          in_act,
  output logic          last_act,
  output logic          at_end,
  output logic [TW-1:0] act_idx
);
  logic [TW-1:0] pos;
  logic [TW-1:0] act_start, act_stop, total;

  always_comb begin
    act_start = sync_len + bp_len;
    act_stop  = act_start + act_len;
    total     = act_stop + fp_len;
    in_sync   = pos < sync_len;
    in_act    = (pos >= act_start) && (pos < act_stop);
    last_act  = pos == (act_stop - 1'b1);
    at_end    = pos >= (total - 1'b1);
    act_idx   = pos - act_start;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pos <= '0;
    else if (step)   pos <= at_end ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/tgen_regs.sv
module tgen_regs
  import disp_tgen_pkg::*;
#(
  parameter int CW = 12,
  parameter int TW = CW + 2,
  parameter int DEF_HSW = 1, parameter int DEF_HBP = 3,
  parameter int DEF_HACT = 7, parameter int DEF_HFP = 2,
  parameter int DEF_VSW = 0, parameter int DEF_VBP = 2,
  parameter int DEF_VACT = 3, parameter int DEF_VFP = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_addr,
  output logic [31:0]   rd_data,
  input  logic          frame_evt,
  output logic          gen_en,
  output logic          dgate_en,
  output logic          hneg,
  output logic          vneg,
  output logic          stat_raw,
  output logic          int_en,
  output logic [TW-1:0] w_hsync, w_hbp, w_hact, w_hfp,
  output logic [TW-1:0] w_vsync, w_vbp, w_vact, w_vfp
);
  logic [CW-1:0]       s_hsw, s_hbp, s_hact, s_hfp;
  logic [CW-1:0]       s_vbp, s_vact, s_vfp;
  logic [VSW_BITS-1:0] s_vsw;
  logic [TW-1:0]       vsw_len;
  logic                clr_req;

  always_comb begin
    vsw_len = (int'(s_vsw) >= VSW_CAP) ? TW'(VSW_CAP) : TW'(s_vsw) + 1'b1;
    clr_req = wr_en && (wr_addr == RA_ICLR) && wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {vneg, hneg, dgate_en, gen_en} <= '0;
      int_en <= 1'b0;
      s_hsw <= CW'(DEF_HSW); s_hbp <= CW'(DEF_HBP);
      s_hact <= CW'(DEF_HACT); s_hfp <= CW'(DEF_HFP);
      s_vsw <= VSW_BITS'(DEF_VSW); s_vbp <= CW'(DEF_VBP);
      s_vact <= CW'(DEF_VACT); s_vfp <= CW'(DEF_VFP);
    end else if (wr_en) begin
      unique case (wr_addr)
        RA_CTRL: {vneg, hneg, dgate_en, gen_en} <= wr_data[3:0];
        RA_HPOR: begin s_hbp <= wr_data[HI_LSB +: CW]; s_hfp <= wr_data[CW-1:0]; end
        RA_HSW:  s_hsw <= wr_data[CW-1:0];
        RA_VPOR: begin s_vbp <= wr_data[HI_LSB +: CW]; s_vfp <= wr_data[CW-1:0]; end
        RA_VSW:  s_vsw <= wr_data[VSW_BITS-1:0];
        RA_SIZE: begin s_vact <= wr_data[HI_LSB +: CW]; s_hact <= wr_data[CW-1:0]; end
        RA_IEN:  int_en <= wr_data[0];
        default: ;
      endcase
    end
  end

  // working set: loaded from shadow only at the frame-end event
  always_ff @(posedge clk) begin
    if (rst) begin
      w_hsync <= TW'(DEF_HSW + 1); w_hbp <= TW'(DEF_HBP);
      w_hact  <= TW'(DEF_HACT + 1); w_hfp <= TW'(DEF_HFP);
      w_vsync <= TW'(DEF_VSW + 1); w_vbp <= TW'(DEF_VBP);
      w_vact  <= TW'(DEF_VACT + 1); w_vfp <= TW'(DEF_VFP);
    end else if (frame_evt) begin
      w_hsync <= TW'(s_hsw) + 1'b1; w_hbp <= TW'(s_hbp);
      w_hact  <= TW'(s_hact) + 1'b1; w_hfp <= TW'(s_hfp);
      w_vsync <= vsw_len;            w_vbp <= TW'(s_vbp);
      w_vact  <= TW'(s_vact) + 1'b1; w_vfp <= TW'(s_vfp);
    end
  end

  // sticky status: a frame end on the same edge beats a clear
  always_ff @(posedge clk) begin
    if (rst)            stat_raw <= 1'b0;
    else if (frame_evt) stat_raw <= 1'b1;
    else if (clr_req)   stat_raw <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      unique case (rd_addr)
        RA_CTRL: rd_data[3:0] <= {vneg, hneg, dgate_en, gen_en};
        RA_HPOR: begin rd_data[HI_LSB +: CW] <= s_hbp; rd_data[CW-1:0] <= s_hfp; end
        RA_HSW:  rd_data[CW-1:0] <= s_hsw;
        RA_VPOR: begin rd_data[HI_LSB +: CW] <= s_vbp; rd_data[CW-1:0] <= s_vfp; end
        RA_VSW:  rd_data[VSW_BITS-1:0] <= s_vsw;
        RA_SIZE: begin rd_data[HI_LSB +: CW] <= s_vact; rd_data[CW-1:0] <= s_hact; end
        RA_IEN:  rd_data[0] <= int_en;
        RA_ICLR: rd_data[0] <= stat_raw & int_en;
        default: ;
      endcase
    end
  end

  assert_vsw_cap_R3: assert property (@(posedge clk) disable iff (rst)
    int'(w_vsync) <= VSW_CAP);
  assert_set_src_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_raw) |-> $past(frame_evt));
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !frame_evt) |=> !stat_raw);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    frame_evt |=> stat_raw);
endmodule

// File: rtl/disp_tgen.sv
module disp_tgen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] px_x,
  output logic [CW-1:0] px_y,
  output logic          frame_end_o,
  output logic          irq_o
);
  localparam int TW = CW + 2;

  logic gen_en, dgate_en, hneg, vneg, stat_raw, int_en;
  logic [TW-1:0] w_hsync, w_hbp, w_hact, w_hfp;
  logic [TW-1:0] w_vsync, w_vbp, w_vact, w_vfp;
  logic h_sync, h_act, h_last, h_end;
  logic v_sync, v_act, v_last, v_end;
  logic [TW-1:0] h_idx, v_idx;
  logic evt_q, both_act;

  tgen_regs #(.CW(CW), .TW(TW)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .frame_evt(evt_q), .gen_en, .dgate_en, .hneg, .vneg, .stat_raw, .int_en,
    .w_hsync, .w_hbp, .w_hact, .w_hfp, .w_vsync, .w_vbp, .w_vact, .w_vfp
  );

  tgen_axis #(.TW(TW)) u_hax (
    .clk, .rst, .run(gen_en), .step(1'b1),
    .sync_len(w_hsync), .bp_len(w_hbp), .act_len(w_hact), .fp_len(w_hfp),
    .in_sync(h_sync), .in_act(h_act), .last_act(h_last), .at_end(h_end),
    .act_idx(h_idx)
  );

  tgen_axis #(.TW(TW)) u_vax (
    .clk, .rst, .run(gen_en), .step(h_end),
    .sync_len(w_vsync), .bp_len(w_vbp), .act_len(w_vact), .fp_len(w_vfp),
    .in_sync(v_sync), .in_act(v_act), .last_act(v_last), .at_end(v_end),
    .act_idx(v_idx)
  );

  assign both_act = gen_en && h_act && v_act;
  assign irq_o    = stat_raw & int_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0; vsync_o <= 1'b0; de_o <= 1'b0;
      px_x <= '0; px_y <= '0; evt_q <= 1'b0; frame_end_o <= 1'b0;
    end else begin
      hsync_o     <= (gen_en && h_sync) ^ hneg;
      vsync_o     <= (gen_en && v_sync) ^ vneg;
      de_o        <= both_act && dgate_en;
      px_x        <= both_act ? h_idx[CW-1:0] : '0;
      px_y        <= both_act ? v_idx[CW-1:0] : '0;
      evt_q       <= gen_en && h_last && v_last;
      frame_end_o <= evt_q;
    end
  end

  assert_de_gen_R10: assert property (@(posedge clk) disable iff (rst)
    de_o |-> $past(gen_en) && $past(dgate_en));
  assert_idle_sync_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(gen_en) |-> (hsync_o == $past(hneg)) && (vsync_o == $past(vneg)));
  assert_fe_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> !frame_end_o);
  assert_fe_no_de_R6: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |-> !de_o);
  assert_irq_fe_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_end_o && int_en) |-> irq_o);
endmodule

// File: tb/disp_tgen_bench.sv
module disp_tgen_bench;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic hsync_o, vsync_o, de_o, frame_end_o, irq_o;
  logic [CW-1:0] px_x, px_y;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  disp_tgen #(.CW(CW)) u_disp_tgen (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .hsync_o, .vsync_o, .de_o, .px_x, .px_y, .frame_end_o, .irq_o
  );

  // hsw-1, hbp, w-1, hfp, vsw-1, vbp, h-1, vfp, pol, frame, de, hs cyc, vs cyc
  localparam int NV = 4;
  localparam int VEC [NV][13] = '{
    '{0, 0, 3, 0, 15, 1, 1, 0, 0,  90,  8, 18, 75},
    '{3, 1, 9, 5,  2, 0, 4, 2, 3, 200, 50, 40, 60},
    '{0, 2, 0, 1,  1, 1, 0, 3, 1,  35,  1,  7, 10},
    '{1, 3, 7, 2,  0, 2, 3, 1, 0, 120, 32, 16, 15}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_fe();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!frame_end_o && n < 20000);
    if (!frame_end_o) chk(1'b0, "R6", "frame end timeout", n, 0);
  endtask

  // counts one whole frame, starting on a frame_end cycle
  task automatic measure(input bit hneg, input bit vneg, output int cyc,
                         output int de_n, output int hs_n, output int vs_n,
                         output int mx, output int my);
    cyc = 0; de_n = 0; hs_n = 0; vs_n = 0; mx = 0; my = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (de_o) begin
        de_n++;
        if (int'(px_x) > mx) mx = int'(px_x);
        if (int'(px_y) > my) my = int'(px_y);
      end
      if (hsync_o != hneg) hs_n++;
      if (vsync_o != vneg) vs_n++;
    end while (!frame_end_o && cyc < 20000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int cyc, de_n, hs_n, vs_n, mx, my;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    repeat (5) begin
      @(negedge clk);
      chk(!hsync_o && !vsync_o && !de_o, "R11", "idle outputs", {hsync_o, vsync_o, de_o}, 0);
      chk(!frame_end_o && !irq_o, "R11", "no event", {frame_end_o, irq_o}, 0);
    end
    rd(3'd5, rv);
    chk(rv == 32'h0003_0007, "R11", "default size", rv, 32'h0003_0007);

    // default mode once enabled: R11 geometry
    wr(3'd0, 32'h3);
    wait_fe();
    measure(1'b0, 1'b0, cyc, de_n, hs_n, vs_n, mx, my);
    chk(cyc == 120, "R11", "default frame length", cyc, 120);

    // vector table: R1 R2 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, (VEC[i][1] << 16) | VEC[i][3]);
      wr(3'd2, VEC[i][0]);
      wr(3'd3, (VEC[i][5] << 16) | VEC[i][7]);
      wr(3'd4, VEC[i][4]);
      wr(3'd5, (VEC[i][6] << 16) | VEC[i][2]);
      wr(3'd0, 3 | (VEC[i][8] << 2));
      wait_fe();
      wait_fe();
      measure(VEC[i][8][0], VEC[i][8][1], cyc, de_n, hs_n, vs_n, mx, my);
      chk(cyc == VEC[i][9], "R1", "frame length", cyc, VEC[i][9]);
      chk(de_n == VEC[i][10], "R4", "de count", de_n, VEC[i][10]);
      chk(hs_n == VEC[i][11], "R2", "hsync cycles (R9 level)", hs_n, VEC[i][11]);
      chk(vs_n == VEC[i][12], "R3", "vsync cycles (R9 level)", vs_n, VEC[i][12]);
      chk(mx == VEC[i][2], "R4", "max px_x", mx, VEC[i][2]);
      chk(my == VEC[i][6], "R4", "max px_y", my, VEC[i][6]);
    end
    rd(3'd4, rv);
    chk(rv == 32'd0, "R3", "vsync field readback", rv, 0);

    // R6: frame_end_o comes the cycle after the last de cycle
    begin
      logic prev_de = 1'b0;
      int n = 0;
      do begin
        @(negedge clk);
        n++;
        if (!frame_end_o) prev_de = de_o;
      end while (!frame_end_o && n < 20000);
      chk(prev_de && !de_o, "R6", "de before frame end", prev_de, 1);
      @(negedge clk);
      chk(!frame_end_o, "R6", "single-cycle pulse", frame_end_o, 0);
    end

    // R5: mid-frame write leaves the current frame untouched
    wait_fe();
    cyc = 0;
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'h0001_0003;
    @(negedge clk);
    cyc++;
    wr_en = 1'b0;
    while (!frame_end_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 120, "R5", "frame after size write", cyc, 120);
    rd(3'd5, rv);
    chk(rv == 32'h0001_0003, "R5", "shadow readback", rv, 32'h0001_0003);
    wait_fe();
    measure(1'b0, 1'b0, cyc, de_n, hs_n, vs_n, mx, my);
    chk(cyc == 66, "R5", "new frame length", cyc, 66);
    chk(de_n == 8, "R5", "new de count", de_n, 8);

    // R7: status masked until enabled
    rd(3'd7, rv);
    chk(rv == 32'd0, "R7", "masked status while disabled", rv, 0);
    chk(!irq_o, "R7", "irq masked", irq_o, 0);
    wr(3'd6, 32'h1);
    chk(irq_o, "R7", "irq after enable", irq_o, 1);
    rd(3'd7, rv);
    chk(rv == 32'd1, "R7", "masked status read", rv, 1);

    // R8: plain clear, right after a frame end
    wait_fe();
    wr(3'd7, 32'h1);
    chk(!irq_o, "R8", "cleared", irq_o, 0);
    wr(3'd7, 32'h0);
    chk(!irq_o, "R8", "zero write keeps cleared", irq_o, 0);
    wait_fe();
    chk(irq_o, "R7", "irq with frame end", irq_o, 1);

    // R8: clear on the same edge as the frame-end set
    repeat (65) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(frame_end_o, "R8", "collision at frame end", frame_end_o, 1);
    chk(irq_o, "R8", "set wins over clear", irq_o, 1);
    repeat (4) @(negedge clk);
    chk(irq_o, "R8", "status still set", irq_o, 1);

    // R10: data gate off
    wr(3'd0, 32'h1);
    wait_fe();
    measure(1'b0, 1'b0, cyc, de_n, hs_n, vs_n, mx, my);
    chk(de_n == 0, "R10", "de gated", de_n, 0);
    chk(cyc == 66, "R10", "timing runs while gated", cyc, 66);

    // R10: generator off, active-low syncs idle high (R9)
    wr(3'd0, 32'hC);
    @(negedge clk);
    begin
      int bad = 0;
      repeat (300) begin
        @(negedge clk);
        if (de_o || frame_end_o || !hsync_o || !vsync_o) bad++;
      end
      chk(bad == 0, "R10", "idle cycles wrong", bad, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule